// File: doc/BRIEF.md
# Staged Column ADC Sequencer

This block sequences the digital side of a single image-sensor column converter that builds an 8-bit pixel code while the photodiode is still integrating. A single 1-bit comparator is reused for every decision. The frame is cut into four sub-frame steps that fall when the elapsed integration time reaches one eighth, one quarter, one half and the whole frame. Each step resolves two more bits, starting with the most significant pair, against a reference code the block drives to an external DAC.

At each step the bits already decided are re-expressed at the current step's scale, because the integrated signal doubles between steps. With this scheme every reference is a sum drawn from only eight binary weights. The two fresh decisions of a step sit in a 2-bit scratch register. When the fourth step completes, the assembled code is written with a one-cycle strobe to the memory word of the row that was latched at frame start. A new frame start discards any unfinished conversion.

Top module: `col_staged_adc`

## Requirements
- R1: After reset, ref_code is 0 and sample_stb, mem_wr and done are all low.
- R2: Elapsed time is tick minus the tick value seen with frame_start. Step k (k = 0..3) begins when the elapsed time equals FRAME_TICKS >> (3-k). sample_stb is then high for exactly the next cycle.
- R3: Bits are resolved from the most significant down. Step k decides bit 7-2k first and then bit 6-2k, where bit 7 is the MSB of mem_data.
- R4: The threshold for a bit under test at step k is the sum of the scaled weights of the already decided ones plus the test bit's scaled weight. A scaled weight is 2^b >> (3-k) for bit b. This gives a first threshold of 16 in step 0.
- R5: A bit is kept (set to 1) exactly when cmp_in is 1 at its decision point, meaning the sample is at or above ref_code.
- R6: Each threshold is held on ref_code for SETTLE+1 cycles. cmp_in is captured on the last of them.
- R7: After the last decision of step 3, mem_wr and done pulse for one cycle together. mem_data carries the 8-bit code and mem_addr carries row_idx as latched at frame_start.
- R8: A frame_start that arrives before step 3 finishes discards the partial result, and no memory write is made for that frame.
- R9: A static pixel with samples 25, 50, 100 and 200 at the four steps sees thresholds 16, 24, 56, 52, 100, 102, 202, 201 and produces code 200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Starts a new integration frame; aborts any pending one |
| tick | input | TW | Free-running integration time counter |
| cmp_in | input | 1 | Comparator decision, 1 when sample is at or above reference |
| row_idx | input | RW | Row being integrated, latched at frame start |
| ref_code | output | 8 | Reference code to the DAC, 0 when not converting |
| sample_stb | output | 1 | Sample-and-hold strobe at the start of each step |
| mem_wr | output | 1 | Write strobe for the pixel memory |
| mem_addr | output | RW | Row address of the write |
| mem_data | output | 8 | Converted pixel code |
| done | output | 1 | One-cycle pulse when a row's conversion completes |

## Verification
The bench drives the static-pixel case of value 200 and matches all eight thresholds against the listed constants. A design with a mis-scaled weight or a wrong carry of earlier bits into a later step shows a different threshold and a wrong code. Full scale (255) and zero test the ends of the comparison: an off-by-one in the at-or-above rule loses the final LSB of 255. Strobe timing is checked against the tick offset of every step, which catches equal spacing or a missing offset. An abort after two steps catches a design that still writes a stale or partial code. Two different rows catch an address taken late instead of at frame start.

// File: rtl/col_staged_adc.sv
module col_staged_adc #(
  parameter int TW = 12,
  parameter int RW = 5,
  parameter int FRAME_TICKS = 64,
  parameter int SETTLE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic [TW-1:0] tick,
  input  logic          cmp_in,
  input  logic [RW-1:0] row_idx,
  output logic [7:0]    ref_code,
  output logic          sample_stb,
  output logic          mem_wr,
  output logic [RW-1:0] mem_addr,
  output logic [7:0]    mem_data,
  output logic          done
);
  localparam int CW = (SETTLE > 0) ? $clog2(SETTLE + 1) : 1;

  logic          active, busy, bsel;
  logic [1:0]    step, tmp;
  logic [7:0]    acc;
  logic [CW-1:0] cnt;
  logic [TW-1:0] base;

  wire [1:0]    sh      = 2'd3 - step;
  wire [TW-1:0] elapsed = tick - base;
  wire [TW-1:0] target  = TW'(FRAME_TICKS >> sh);
  wire [2:0]    pos     = 3'd7 - {step, 1'b0} - {2'b00, bsel};
  wire [7:0]    trial   = acc | ({tmp, 6'b0} >> {step, 1'b0}) | (8'd1 << pos);
  wire [7:0]    merged  = acc | ({tmp[1], cmp_in, 6'b0} >> {step, 1'b0});
  wire          last    = (cnt == CW'(SETTLE));

  assign ref_code = busy ? (trial >> sh) : 8'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; busy <= 1'b0; bsel <= 1'b0;
      step <= '0; tmp <= '0; acc <= '0; cnt <= '0; base <= '0;
      sample_stb <= 1'b0; mem_wr <= 1'b0; done <= 1'b0;
      mem_addr <= '0; mem_data <= '0;
    end else begin
      sample_stb <= 1'b0;
      mem_wr     <= 1'b0;
      done       <= 1'b0;
      if (frame_start) begin
        active   <= 1'b1;
        busy     <= 1'b0;
        bsel     <= 1'b0;
        base     <= tick;
        step     <= '0;
        acc      <= '0;
        tmp      <= '0;
        cnt      <= '0;
        mem_addr <= row_idx;
      end else if (active && !busy) begin
        if (elapsed == target) begin
          busy       <= 1'b1;
          sample_stb <= 1'b1;
          bsel       <= 1'b0;
          cnt        <= '0;
          tmp        <= '0;
        end
      end else if (busy) begin
        if (!last) begin
          cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
          if (!bsel) begin
            tmp[1] <= cmp_in;
            bsel   <= 1'b1;
          end else begin
            tmp[0] <= cmp_in;
            acc    <= merged;
            busy   <= 1'b0;
            bsel   <= 1'b0;
            if (step == 2'd3) begin
              mem_wr   <= 1'b1;
              done     <= 1'b1;
              mem_data <= merged;
              active   <= 1'b0;
            end else begin
              step <= step + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/col_staged_adc_chk.sv
module col_staged_adc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_start,
  input logic       sample_stb,
  input logic       mem_wr,
  input logic       busy,
  input logic       cnt_nz,
  input logic [1:0] step,
  input logic [7:0] ref_code
);
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) sample_stb |=> !sample_stb); // R2
  AST_REF_SCALE:  assert property (@(posedge clk) disable iff (!rst_n) busy |-> (ref_code <= (8'hFF >> (2'd3 - step)))); // R4
  AST_REF_HELD:   assert property (@(posedge clk) disable iff (!rst_n) (busy && cnt_nz) |-> $stable(ref_code)); // R6
  AST_WR_SINGLE:  assert property (@(posedge clk) disable iff (!rst_n) mem_wr |=> !mem_wr); // R7
  AST_ABORT_NOWR: assert property (@(posedge clk) disable iff (!rst_n) frame_start |=> !mem_wr); // R8
endmodule

bind col_staged_adc col_staged_adc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .sample_stb(sample_stb),
  .mem_wr(mem_wr), .busy(busy), .cnt_nz(cnt != '0), .step(step), .ref_code(ref_code)
);

// File: tb/col_staged_adc_test.sv
module col_staged_adc_test;
  localparam int CLK_P = 10;
  localparam int TW = 12;
  localparam int RW = 5;
  localparam int FRAME_TICKS = 64;
  localparam int SETTLE = 2;

  logic clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0;
  logic [TW-1:0] tick = '0;
  logic [RW-1:0] row_idx = '0;
  logic [7:0] samp = '0;
  logic [7:0] ref_code, mem_data;
  logic [RW-1:0] mem_addr;
  logic sample_stb, mem_wr, done;
  wire cmp_in = (samp >= ref_code);

  col_staged_adc #(.TW(TW), .RW(RW), .FRAME_TICKS(FRAME_TICKS), .SETTLE(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .tick(tick), .cmp_in(cmp_in),
    .row_idx(row_idx), .ref_code(ref_code), .sample_stb(sample_stb), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_data(mem_data), .done(done));

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) tick <= tick + 1'b1;

  int total = 0, bad = 0;
  int exp_thr[$];
  int exp_wr[$];
  int exp_row[$];
  logic [TW-1:0] base_t = '0;
  int stb_n = 0, cur_val = 0, pend = 0, first_thr = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(input int v, input int nsteps, output int thr[8], output int code);
    bit d[8];
    for (int i = 0; i < 8; i++) d[i] = 0;
    code = 0;
    for (int k = 0; k < nsteps; k++) begin
      int s;
      s = (v << k) >> 3;
      for (int j = 0; j < 2; j++) begin
        int b, t;
        b = 7 - 2*k - j;
        t = (1 << b) >> (3 - k);
        for (int i = 7; i > b; i--) if (d[i]) t += (1 << i) >> (3 - k);
        thr[2*k + j] = t;
        d[b] = (s >= t);
      end
    end
    for (int i = 0; i < 8; i++) if (d[i]) code += (1 << i);
  endtask

  task automatic run_frame(input int v, input int row, input int nsteps);
    int thr[8];
    int code;
    @(negedge clk);
    row_idx = RW'(row);
    frame_start = 1'b1;
    base_t = tick;
    cur_val = v;
    stb_n = 0;
    model(v, nsteps, thr, code);
    for (int i = 0; i < 2*nsteps; i++) exp_thr.push_back(thr[i]);
    if (nsteps == 4) begin
      exp_wr.push_back(code);
      exp_row.push_back(row);
    end
    @(negedge clk);
    frame_start = 1'b0;
    row_idx = RW'(row + 7);
    if (nsteps == 4) repeat (FRAME_TICKS + 2*(SETTLE+1) + 4) @(negedge clk);
    else repeat ((FRAME_TICKS >> (4 - nsteps)) + 2*(SETTLE+1) + 2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (pend != 0) begin
        pend--;
        if (pend == 1)
          chk(ref_code == 8'(first_thr), "R6 threshold held through settle", ref_code, first_thr);
        if (pend == 0) begin
          if (exp_thr.size() == 0) chk(0, "R3 R4 unexpected second threshold", ref_code, -1);
          else begin
            int e;
            e = exp_thr.pop_front();
            chk(ref_code == 8'(e), "R3 R4 second threshold of step", ref_code, e);
          end
        end
      end
      if (sample_stb) begin
        int want;
        want = (FRAME_TICKS >> (3 - stb_n)) + 1;
        chk(int'(TW'(tick - base_t)) == want, "R2 step strobe time", int'(TW'(tick - base_t)), want);
        samp = 8'((cur_val << stb_n) >> 3);
        stb_n++;
        if (exp_thr.size() == 0) chk(0, "R3 R4 unexpected first threshold", ref_code, -1);
        else begin
          first_thr = exp_thr.pop_front();
          chk(ref_code == 8'(first_thr), "R3 R4 first threshold of step", ref_code, first_thr);
        end
        pend = SETTLE + 1;
      end
      if (mem_wr) begin
        if (exp_wr.size() == 0) chk(0, "R8 write from aborted frame", mem_data, -1);
        else begin
          int e, r;
          e = exp_wr.pop_front();
          r = exp_row.pop_front();
          chk(mem_data == 8'(e), "R5 R7 written code", mem_data, e);
          chk(mem_addr == RW'(r), "R7 write row", mem_addr, r);
          chk(done == 1'b1, "R7 done with write", done, 1);
        end
      end
    end
  end

  initial begin
    int thr[8];
    int code;
    int ref200[8] = '{16, 24, 56, 52, 100, 102, 202, 201};
    repeat (3) @(negedge clk);
    chk(ref_code == 8'd0, "R1 ref after reset", ref_code, 0);
    chk(sample_stb == 1'b0, "R1 strobe after reset", sample_stb, 0);
    chk(mem_wr == 1'b0, "R1 write after reset", mem_wr, 0);
    chk(done == 1'b0, "R1 done after reset", done, 0);
    rst_n = 1'b1;
    model(200, 4, thr, code);
    for (int i = 0; i < 8; i++) chk(thr[i] == ref200[i], "R9 weight table for 200", thr[i], ref200[i]);
    chk(code == 200, "R9 staged code for 200", code, 200);
    run_frame(200, 2, 4);
    run_frame(255, 9, 4);
    run_frame(0, 17, 4);
    run_frame(180, 3, 2);
    run_frame(90, 4, 4);
    run_frame(131, 30, 4);
    repeat (5) @(negedge clk);
    chk(exp_thr.size() == 0, "R4 thresholds left unseen", exp_thr.size(), 0);
    chk(exp_wr.size() == 0, "R7 writes left unseen", exp_wr.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog R7 run did not complete actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule